// File: doc/BRIEF.md
# Byte-Oriented Register ALU Executor

This block executes the register-to-accumulator arithmetic and logic instructions of a small 8-bit accumulator machine. Each accepted instruction word names an operation, a 7-bit address into a 128-entry register file held inside the block, and a destination bit. The block combines the addressed register with the accumulator. It stores the result either back into that register or into the accumulator, and it updates the status flags that the operation calls for.

A conditional decrement that reaches zero raises a skip request. The cycle after it is then spent as the skipped slot: any instruction presented during that cycle is discarded. A cycle-count output reports how many cycles the most recently accepted instruction consumed. The accumulator, the flags and a combinational register read port let the surrounding core, or a test, observe the state.

Top module: `reg_alu_exec`

## Requirements
- R1: After reset, the accumulator, all 128 registers, and the zero, carry and digital-carry flags read 0. The skip output and the cycle count are also 0.
- R2: The instruction word is `01` in bits 13:12, a 4-bit operation in bits 11:8, a destination bit in bit 7 and a register address in bits 6:0. With the destination bit at 0 the result goes to the accumulator and the register is left unchanged. With the destination bit at 1 the result goes to the register and the accumulator is left unchanged.
- R3: Operations 0100 (AND), 1011 (XOR) and 1111 (OR) combine the register with the accumulator bitwise. They update only the zero flag.
- R4: Operation 0101 adds the accumulator and the register. Carry is the carry out of bit 7, digital carry is the carry out of bit 3, and zero is set when the 8-bit result is 0x00.
- R5: Operation 1010 computes register minus accumulator. Carry is 1 exactly when no borrow occurs (register >= accumulator). Digital carry is 1 exactly when the low nibble of the register is >= the low nibble of the accumulator. Zero follows the result.
- R6: Operation 0110 decrements the register, so 0x00 becomes 0xFF. It updates only the zero flag.
- R7: Operation 0111 decrements the register and changes no flag. When the result is 0x00, skip_o is 1 during the following cycle and the cycle count reads 2.
- R8: An instruction presented while skip_o is 1 is discarded: no register, accumulator or flag changes. skip_o returns to 0 one cycle later.
- R9: A word with bits 13:12 other than `01`, a word with an operation code outside the seven listed, or a cycle with instr_valid_i at 0 changes no register, accumulator, flag, skip output or cycle count.
- R10: rd_data_o shows, combinationally, the register addressed by rd_addr_i, including writes made at the previous clock edge.
- R11: After every accepted instruction other than a decrement-and-skip that hits zero, the cycle count reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 14 | Instruction word |
| skip_o | output | 1 | Current cycle is the skipped slot |
| cycles_o | output | 2 | Cycles used by the last accepted instruction |
| acc_o | output | 8 | Accumulator |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / no-borrow flag |
| dcarry_o | output | 1 | Nibble carry / no-borrow flag |
| rd_addr_i | input | 7 | Register read address |
| rd_data_o | output | 8 | Register read data |

## Verification
The bench targets several specific cases.

- Borrow polarity in subtraction. Building 0x01 as 0x00 minus 0xFF and then comparing equal operands exposes a design that inverts carry or digital carry, or that swaps the operand order.
- Decrement wrap from 0x00 to 0xFF. This catches a design that saturates at zero or that lets decrement disturb carry.
- The conditional decrement that reaches zero. It is followed by an instruction that must vanish in the skipped slot; a design without the slot would change the accumulator there.
- Illegal prefixes and unlisted operation codes. They are mixed into a long random stream over a few hot registers, so a decoder that accepts them would corrupt state and diverge from the reference model at once.

// File: rtl/rax_pkg.sv
package rax_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0100,
    OP_ADD = 4'b0101,
    OP_DEC = 4'b0110,
    OP_DSZ = 4'b0111,
    OP_SUB = 4'b1010,
    OP_XOR = 4'b1011,
    OP_IOR = 4'b1111
  } rax_op_e;

  typedef struct packed {
    logic    legal;
    rax_op_e op;
    logic    to_reg;
  } rax_dec_t;

  localparam logic [1:0] RAX_PREFIX = 2'b01;

endpackage

// File: rtl/rax_decode.sv
module rax_decode
  import rax_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int INSTR_W = ADDR_W + 7
) (
  input  logic [INSTR_W-1:0] instr,
  output rax_dec_t           dec,
  output logic [ADDR_W-1:0]  addr
);

  logic [1:0] prefix;
  logic [3:0] op_raw;
  logic       known;

  assign prefix = instr[INSTR_W-1:INSTR_W-2];
  assign op_raw = instr[INSTR_W-3:ADDR_W+1];
  assign addr   = instr[ADDR_W-1:0];

  always_comb begin
    unique case (op_raw)
      4'b0100, 4'b0101, 4'b0110, 4'b0111,
      4'b1010, 4'b1011, 4'b1111: known = 1'b1;
      default:                   known = 1'b0;
    endcase
  end

  always_comb begin
    dec.legal  = known && (prefix == RAX_PREFIX);
    dec.op     = rax_op_e'(op_raw);
    dec.to_reg = instr[ADDR_W];
  end

endmodule

// File: rtl/rax_alu.sv
module rax_alu
  import rax_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rax_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] res,
  output logic              z_new,
  output logic              c_new,
  output logic              dc_new,
  output logic              upd_z,
  output logic              upd_cdc,
  output logic              skip_hit
);

  localparam int NIB_W = 4;

  logic [DATA_W:0]  sum_w;
  logic [DATA_W:0]  dif_w;
  logic [NIB_W:0]   nsum_w;
  logic [NIB_W:0]   ndif_w;
  logic [DATA_W-1:0] dec_w;

  assign sum_w  = {1'b0, opnd} + {1'b0, acc};
  assign dif_w  = {1'b0, opnd} - {1'b0, acc};
  assign nsum_w = {1'b0, opnd[NIB_W-1:0]} + {1'b0, acc[NIB_W-1:0]};
  assign ndif_w = {1'b0, opnd[NIB_W-1:0]} - {1'b0, acc[NIB_W-1:0]};
  assign dec_w  = opnd - DATA_W'(1);

  always_comb begin
    res     = '0;
    c_new   = 1'b0;
    dc_new  = 1'b0;
    upd_z   = 1'b1;
    upd_cdc = 1'b0;
    unique case (op)
      OP_AND: res = opnd & acc;
      OP_XOR: res = opnd ^ acc;
      OP_IOR: res = opnd | acc;
      OP_DEC: res = dec_w;
      OP_DSZ: begin
        res   = dec_w;
        upd_z = 1'b0;
      end
      OP_ADD: begin
        res     = sum_w[DATA_W-1:0];
        c_new   = sum_w[DATA_W];
        dc_new  = nsum_w[NIB_W];
        upd_cdc = 1'b1;
      end
      OP_SUB: begin
        res     = dif_w[DATA_W-1:0];
        c_new   = ~dif_w[DATA_W];
        dc_new  = ~ndif_w[NIB_W];
        upd_cdc = 1'b1;
      end
      default: upd_z = 1'b0;
    endcase
  end

  assign z_new    = (res == '0);
  assign skip_hit = (op == OP_DSZ) && (dec_w == '0);

endmodule

// File: rtl/rax_regfile.sv
module rax_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic ent_en;
    assign ent_en = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (ent_en) begin
        mem_q[g] <= wdata;
      end
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/reg_alu_exec.sv
module reg_alu_exec
  import rax_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int DEPTH   = 1 << ADDR_W,
  localparam int INSTR_W = ADDR_W + 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               skip_o,
  output logic [1:0]         cycles_o,
  output logic [DATA_W-1:0]  acc_o,
  output logic               zero_o,
  output logic               carry_o,
  output logic               dcarry_o,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rax_dec_t          dec;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] res;
  logic              z_new, c_new, dc_new, upd_z, upd_cdc, skip_hit;

  rax_decode #(.ADDR_W(ADDR_W)) u_dec (
    .instr (instr_i),
    .dec   (dec),
    .addr  (op_addr)
  );

  rax_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (dec.op),
    .acc      (acc_o),
    .opnd     (opnd),
    .res      (res),
    .z_new    (z_new),
    .c_new    (c_new),
    .dc_new   (dc_new),
    .upd_z    (upd_z),
    .upd_cdc  (upd_cdc),
    .skip_hit (skip_hit)
  );

  logic exec;
  logic rf_we;

  assign exec  = instr_valid_i && dec.legal && !skip_o;
  assign rf_we = exec && dec.to_reg;

  rax_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we      (rf_we),
    .waddr   (op_addr),
    .wdata   (res),
    .raddr_a (op_addr),
    .rdata_a (opnd),
    .raddr_b (rd_addr_i),
    .rdata_b (rd_data_o)
  );

  logic [DATA_W-1:0] acc_d;
  logic              z_d, c_d, dc_d, skip_d;
  logic [1:0]        cyc_d;
  logic              st_en;

  always_comb begin
    acc_d  = acc_o;
    z_d    = zero_o;
    c_d    = carry_o;
    dc_d   = dcarry_o;
    cyc_d  = cycles_o;
    skip_d = 1'b0;
    if (exec) begin
      if (!dec.to_reg) acc_d = res;
      if (upd_z)       z_d   = z_new;
      if (upd_cdc) begin
        c_d  = c_new;
        dc_d = dc_new;
      end
      skip_d = skip_hit;
      cyc_d  = skip_hit ? 2'd2 : 2'd1;
    end
  end

  assign st_en = exec || skip_o;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_o    <= '0;
      zero_o   <= 1'b0;
      carry_o  <= 1'b0;
      dcarry_o <= 1'b0;
      cycles_o <= 2'd0;
      skip_o   <= 1'b0;
    end else if (st_en) begin
      acc_o    <= acc_d;
      zero_o   <= z_d;
      carry_o  <= c_d;
      dcarry_o <= dc_d;
      cycles_o <= cyc_d;
      skip_o   <= skip_d;
    end
  end

endmodule

// File: rtl/rax_chk.sv
module rax_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  localparam int INSTR_W = ADDR_W + 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic               skip_o,
  input logic [1:0]         cycles_o,
  input logic [DATA_W-1:0]  acc_o,
  input logic               zero_o,
  input logic               carry_o,
  input logic               dcarry_o
);

  logic [1:0] pre;
  logic [3:0] opc;
  assign pre = instr_i[INSTR_W-1:INSTR_W-2];
  assign opc = instr_i[INSTR_W-3:ADDR_W+1];

  // R7
  dsz_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i && pre == 2'b01 && opc == 4'b0111
    |=> $stable(zero_o) && $stable(carry_o) && $stable(dcarry_o));

  // R7
  skip_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> cycles_o == 2'd2);

  // R8
  skip_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |=> !skip_o && $stable(acc_o) && $stable(zero_o) && $stable(carry_o));

  // R9
  bad_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i && pre != 2'b01
    |=> $stable(acc_o) && $stable(zero_o) && $stable(carry_o) && $stable(dcarry_o) && !skip_o);

  // R6
  dec_zonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i && pre == 2'b01 && opc == 4'b0110
    |=> $stable(carry_o) && $stable(dcarry_o));

  // R3
  logic_zonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i && pre == 2'b01 && (opc == 4'b0100 || opc == 4'b1011 || opc == 4'b1111)
    |=> $stable(carry_o) && $stable(dcarry_o));

endmodule

bind reg_alu_exec rax_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .skip_o        (skip_o),
  .cycles_o      (cycles_o),
  .acc_o         (acc_o),
  .zero_o        (zero_o),
  .carry_o       (carry_o),
  .dcarry_o      (dcarry_o)
);

// File: tb/sim_reg_alu_exec.sv
module sim_reg_alu_exec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid_i;
  logic [13:0] instr_i;
  logic [6:0]  rd_addr_i;
  logic        skip_o;
  logic [1:0]  cycles_o;
  logic [7:0]  acc_o, rd_data_o;
  logic        zero_o, carry_o, dcarry_o;

  always #5 clk = ~clk;

  reg_alu_exec u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .skip_o(skip_o), .cycles_o(cycles_o), .acc_o(acc_o), .zero_o(zero_o),
    .carry_o(carry_o), .dcarry_o(dcarry_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_mem[128];
  int m_acc, m_z, m_c, m_dc, m_skip, m_cyc;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input bit v, input logic [13:0] w, input int skp);
    if (skp != 0) return "R8";
    if (!v || w[13:12] != 2'b01) return "R9";
    case (w[11:8])
      4'b0100, 4'b1011, 4'b1111: return "R3";
      4'b0101: return "R4";
      4'b1010: return "R5";
      4'b0110: return "R6";
      4'b0111: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input bit v, input logic [13:0] w);
    int r, a, res, ad;
    bit ok;
    bit nz = 0;
    bit ncd = 0;
    bit hit = 0;
    ok = v && w[13:12] == 2'b01 && m_skip == 0;
    ad = int'(w[6:0]);
    r = m_mem[ad];
    a = m_acc;
    res = 0;
    case (w[11:8])
      4'b0100: begin res = r & a; nz = 1; end
      4'b1011: begin res = r ^ a; nz = 1; end
      4'b1111: begin res = r | a; nz = 1; end
      4'b0110: begin res = (r + 255) % 256; nz = 1; end
      4'b0111: begin res = (r + 255) % 256; hit = (res == 0); end
      4'b0101: begin
        res = (r + a) % 256; nz = 1; ncd = 1;
        if (ok) begin m_c = (r + a) > 255; m_dc = ((r % 16) + (a % 16)) > 15; end
      end
      4'b1010: begin
        res = (r - a + 256) % 256; nz = 1; ncd = 1;
        if (ok) begin m_c = (r >= a); m_dc = ((r % 16) >= (a % 16)); end
      end
      default: ok = 0;
    endcase
    m_skip = 0;
    if (ok) begin
      if (w[7]) m_mem[ad] = res; else m_acc = res;
      if (nz) m_z = (res == 0);
      m_skip = hit;
      m_cyc = hit ? 2 : 1;
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "acc", int'(acc_o), m_acc);
    chk(tag, "zero", int'(zero_o), m_z);
    chk(tag, "carry", int'(carry_o), m_c);
    chk(tag, "dcarry", int'(dcarry_o), m_dc);
    chk(tag, "skip", int'(skip_o), m_skip);
    chk((tag == "R7") ? "R7" : "R11", "cycles", int'(cycles_o), m_cyc);
    chk("R10", "rd_data", int'(rd_data_o), m_mem[int'(rd_addr_i)]);
  endtask

  task automatic step(input bit v, input logic [13:0] w, input logic [6:0] ra);
    string tag;
    @(negedge clk);
    instr_valid_i = v;
    instr_i = w;
    rd_addr_i = ra;
    tag = tag_of(v, w, m_skip);
    @(posedge clk);
    model(v, w);
    #1;
    compare(tag);
  endtask

  function automatic logic [13:0] mk(input logic [3:0] op, input bit d, input logic [6:0] a);
    return {2'b01, op, d, a};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    instr_valid_i = 0;
    instr_i = '0;
    rd_addr_i = '0;
    rst_n = 0;
    for (int i = 0; i < 128; i++) m_mem[i] = 0;
    m_acc = 0; m_z = 0; m_c = 0; m_dc = 0; m_skip = 0; m_cyc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: every register, flag and output reads zero after reset
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      rd_addr_i = 7'(i);
      #1;
      chk("R1", "reg", int'(rd_data_o), 0);
    end
    chk("R1", "acc", int'(acc_o), 0);
    chk("R1", "flags", int'({zero_o, carry_o, dcarry_o}), 0);
    chk("R1", "skip/cycles", int'({skip_o, cycles_o}), 0);

    // R6: wrap 00 -> FF into register (R2 d=1)
    step(1, mk(4'b0110, 1, 7'd5), 7'd5);
    chk("R2", "acc untouched d=1", int'(acc_o), 0);
    // R4: 00 + FF into acc (R2 d=0)
    step(1, mk(4'b0101, 0, 7'd5), 7'd5);
    chk("R2", "reg untouched d=0", int'(rd_data_o), 8'hFF);
    // R4: FF + FF with both carries
    step(1, mk(4'b0101, 1, 7'd5), 7'd5);
    // R5: FE - FF borrows
    step(1, mk(4'b1010, 0, 7'd5), 7'd5);
    // R5: 00 - FF = 01 into r20
    step(1, mk(4'b1010, 1, 7'd20), 7'd20);
    // R3 logic ops
    step(1, mk(4'b0100, 0, 7'd20), 7'd20);
    step(1, mk(4'b1011, 0, 7'd20), 7'd20);
    step(1, mk(4'b1111, 1, 7'd21), 7'd21);
    // R9: bad prefix, unlisted op, valid low
    step(1, {2'b11, 4'b0101, 1'b1, 7'd20}, 7'd20);
    step(1, {2'b01, 4'b1000, 1'b1, 7'd20}, 7'd20);
    step(0, mk(4'b0110, 1, 7'd20), 7'd20);
    // R7: decrement 01 -> 00 and skip; R8: next word discarded
    step(1, mk(4'b0111, 1, 7'd20), 7'd20);
    chk("R7", "skip high", int'(skip_o), 1);
    step(1, mk(4'b0110, 0, 7'd21), 7'd21);
    step(1, mk(4'b0111, 1, 7'd20), 7'd20);
    // R5: equal operands give no borrow and zero
    step(1, mk(4'b1010, 0, 7'd6), 7'd6);
    step(1, mk(4'b1010, 0, 7'd6), 7'd6);

    for (int n = 0; n < 4000; n++) begin
      logic [3:0] ops[7] = '{4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1010, 4'b1011, 4'b1111};
      int sel = $urandom_range(0, 9);
      logic [13:0] w;
      logic [6:0] ad = 7'($urandom_range(0, 3));
      if (($urandom_range(0, 15)) == 0) ad = 7'($urandom_range(0, 127));
      if (sel < 7)       w = mk(ops[sel], 1'($urandom_range(0, 1)), ad);
      else if (sel == 7) w = {2'b01, 4'b0000 | 4'($urandom_range(0, 3)), 1'b1, ad};
      else if (sel == 8) w = {2'($urandom_range(0, 2)) ^ 2'b10, ops[$urandom_range(0, 6)], 1'b1, ad};
      else               w = mk(ops[$urandom_range(0, 6)], 1'b1, ad);
      step(1'($urandom_range(0, 7) != 0), w, 7'($urandom_range(0, 3)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule